// File: doc/BRIEF.md
# Enclave Memory Access Checker

This block sits directly after address translation and decides, for every memory access, whether it may proceed. It receives the virtual address and the physical address that the untrusted page tables produced, the access kind, the class of requester (enclave code, ordinary host software, or a DMA agent), the active enclave's virtual window and owner identifier, and the ownership record looked up for the target physical page. It answers one clock later with an allow flag and a fault-cause code.

Host software and DMA agents are kept out of a fixed protected physical region. Enclave code is held to a stricter contract. A virtual address inside the enclave's window must land in the protected region. Once the access lands on a protected page, the page record must be valid and owned by this enclave. The page must be of the regular kind, must have been recorded for exactly this virtual page, and must permit the access kind. Enclave accesses that stay outside the window and outside the region go through unchecked. A separate load strobe checks a new window configuration and flags a window whose size is not a power of two or whose base is not aligned to its size.

Top module: `enclave_access_guard`

## Requirements
- R1: A request with source code 2 (DMA) or 3 (treated as DMA) whose physical address lies in the protected region is refused with cause 1.
- R2: A request with source code 1 (host software) whose physical address lies in the protected region is refused with cause 1; host and DMA requests outside the region are allowed with cause 0.
- R3: A virtual address is inside the enclave window exactly when it lies in [base, base+size); the block tests this with a mask-and-compare, which is only valid for a window that passes the R12 check.
- R4: An enclave request (source code 0) whose virtual address is inside the window but whose physical address is outside the protected region faults with cause 2.
- R5: An enclave request landing in the protected region on a page whose record has the valid bit clear faults with cause 3.
- R6: An enclave request landing in the protected region on a page whose recorded owner differs from the current enclave owner faults with cause 4.
- R7: An enclave request landing in the protected region on a page whose type is not 0 (regular) faults with cause 5; type 1 (control structure), type 2 (thread control) and type 3 (reserved) are all refused.
- R8: An enclave request landing in the protected region faults with cause 6 when the recorded virtual page number differs from the virtual address bits above the 4 KiB page offset.
- R9: An enclave request landing in the protected region faults with cause 7 unless the kind is permitted: kind 0 (read) needs R, kind 1 (write) needs W, kind 2 (fetch) needs X; kind 3 is never permitted.
- R10: An enclave request outside the window and outside the protected region is allowed with cause 0 regardless of the page record.
- R11: When several checks fail, the lowest-numbered cause among 1 to 7 is reported.
- R12: On a load strobe, the configuration error output is set on the next cycle when the presented size is zero or not a power of two, or when the base has any bit set below the size, and cleared otherwise; it holds between loads.
- R13: The response valid flag follows the request valid flag by one cycle; with no response, allow and cause read 0; reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_va | input | 32 | Virtual address of the access |
| req_pa | input | 32 | Translated physical address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 illegal |
| req_src | input | 2 | 0 enclave, 1 host, 2 DMA, 3 treated as DMA |
| win_base | input | 32 | Enclave virtual window base |
| win_size | input | 32 | Enclave virtual window size |
| cur_owner | input | 8 | Identifier of the running enclave |
| pg_valid | input | 1 | Page record valid bit |
| pg_type | input | 2 | Page record type: 0 regular, 1 control, 2 thread control, 3 reserved |
| pg_owner | input | 8 | Page record owner identifier |
| pg_vpn | input | 20 | Virtual page number recorded for the page |
| pg_r | input | 1 | Page record read permission |
| pg_w | input | 1 | Page record write permission |
| pg_x | input | 1 | Page record execute permission |
| cfg_load | input | 1 | Strobe: check the presented window configuration |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access allowed |
| rsp_cause | output | 3 | Fault cause, 0 when allowed |
| cfg_err | output | 1 | Last loaded window configuration is illegal |

## Verification
The assertions on window membership and on the mapping fault take for granted that the window presented with each request has passed the configuration check, since mask-and-compare membership means nothing for a misaligned or non-power-of-two window. The stimulus therefore sends requests only with a legal window (several sizes and bases) and presents illegal windows only together with the load strobe while no request is valid. Page records are drawn mostly consistent with the access and then corrupted field by field, often several fields at once, so that every fault cause and the priority among them is reached.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    SRC_ENCL = 2'd0,
    SRC_HOST = 2'd1,
    SRC_DMA  = 2'd2,
    SRC_DMA2 = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_EX  = 2'd2,
    KIND_BAD = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    PG_REG  = 2'd0,
    PG_CTRL = 2'd1,
    PG_THRD = 2'd2,
    PG_RSVD = 2'd3
  } pgtype_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_REGION = 3'd1,
    CAUSE_MAP    = 3'd2,
    CAUSE_VALID  = 3'd3,
    CAUSE_OWNER  = 3'd4,
    CAUSE_TYPE   = 3'd5,
    CAUSE_ADDR   = 3'd6,
    CAUSE_PERM   = 3'd7
  } cause_e;

  localparam int NUM_CHECKS = 7;
  localparam int WIDE_W     = 64;

  typedef logic [WIDE_W-1:0] wide_t;

  // Aligned power-of-two window membership: equal above the size bit.
  function automatic logic f_in_window(wide_t addr, wide_t base, wide_t size);
    wide_t keep;
    keep = ~(size - wide_t'(1));
    return ((addr ^ base) & keep) == '0;
  endfunction

  function automatic logic f_pow2(wide_t v);
    return (v != '0) && ((v & (v - wide_t'(1))) == '0);
  endfunction

  function automatic logic f_aligned(wide_t base, wide_t size);
    return (base & (size - wide_t'(1))) == '0;
  endfunction

  function automatic logic f_perm_ok(kind_e k, logic r, logic w, logic x);
    case (k)
      KIND_RD: return r;
      KIND_WR: return w;
      KIND_EX: return x;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eag_window_match.sv
module eag_window_match
  import eag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] base,
  input  logic [W-1:0] size,
  output logic         hit
);
  wide_t addr_w, base_w, size_w;

  always_comb begin
    addr_w = wide_t'(addr);
    base_w = wide_t'(base);
    size_w = wide_t'(size);
    hit    = f_in_window(addr_w, base_w, size_w);
  end
endmodule

// File: rtl/eag_entry_check.sv
module eag_entry_check
  import eag_pkg::*;
#(
  parameter int OWN_W = 8,
  parameter int VPN_W = 20
) (
  input  kind_e            kind,
  input  logic [VPN_W-1:0] va_vpn,
  input  logic [OWN_W-1:0] cur_owner,
  input  logic             pg_valid,
  input  pgtype_e          pg_type,
  input  logic [OWN_W-1:0] pg_owner,
  input  logic [VPN_W-1:0] pg_vpn,
  input  logic             pg_r,
  input  logic             pg_w,
  input  logic             pg_x,
  output logic             bad_valid,
  output logic             bad_owner,
  output logic             bad_type,
  output logic             bad_addr,
  output logic             bad_perm
);
  always_comb begin
    bad_valid = !pg_valid;
    bad_owner = pg_owner != cur_owner;
    bad_type  = pg_type != PG_REG;
    bad_addr  = pg_vpn != va_vpn;
    bad_perm  = !f_perm_ok(kind, pg_r, pg_w, pg_x);
  end
endmodule

// File: rtl/eag_cause_pick.sv
module eag_cause_pick
  import eag_pkg::*;
#(
  parameter int N = NUM_CHECKS
) (
  input  logic [N-1:0] viol,
  output logic         any_viol,
  output cause_e       cause
);
  // Bit i of viol maps to cause i+1; lowest index wins.
  always_comb begin
    cause = CAUSE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (viol[i]) cause = cause_e'(i + 1);
    end
    any_viol = |viol;
  end
endmodule

// File: rtl/eag_cfg_check.sv
module eag_cfg_check
  import eag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] base,
  input  logic [W-1:0] size,
  output logic         err
);
  logic cfg_illegal;

  always_comb begin
    cfg_illegal = !f_pow2(wide_t'(size)) || !f_aligned(wide_t'(base), wide_t'(size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    err <= 1'b0;
    else if (load) err <= cfg_illegal;
  end

  // R12: a load of a non-power-of-two size must raise the error flag.
  a_r12_bad_size_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ($countones(size) != 1)) |=> err);

  // R12: the flag only moves on a load.
  a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err));
endmodule

// File: rtl/enclave_access_guard.sv
module enclave_access_guard
  import eag_pkg::*;
#(
  parameter int          VA_W       = 32,
  parameter int          PA_W       = 32,
  parameter int          OWN_W      = 8,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [31:0] RGN_BASE   = 32'h4000_0000,
  parameter int          RGN_LOG2   = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_va,
  input  logic [PA_W-1:0]          req_pa,
  input  logic [1:0]               req_kind,
  input  logic [1:0]               req_src,
  input  logic [VA_W-1:0]          win_base,
  input  logic [VA_W-1:0]          win_size,
  input  logic [OWN_W-1:0]         cur_owner,
  input  logic                     pg_valid,
  input  logic [1:0]               pg_type,
  input  logic [OWN_W-1:0]         pg_owner,
  input  logic [VA_W-PAGE_SHIFT-1:0] pg_vpn,
  input  logic                     pg_r,
  input  logic                     pg_w,
  input  logic                     pg_x,
  input  logic                     cfg_load,
  output logic                     rsp_valid,
  output logic                     rsp_allow,
  output logic [2:0]               rsp_cause,
  output logic                     cfg_err
);
  localparam int             VPN_W    = VA_W - PAGE_SHIFT;
  localparam logic [PA_W-1:0] RGN_B   = PA_W'(RGN_BASE);
  localparam logic [PA_W-1:0] RGN_SZ  = PA_W'(1) << RGN_LOG2;

  // Named internal events, shared with the assertions.
  logic   pa_in_rgn;
  logic   va_in_win;
  logic   is_encl;
  logic   e_valid, e_owner, e_type, e_addr, e_perm;
  logic [NUM_CHECKS-1:0] viol;
  logic   any_viol;
  cause_e pick;

  eag_window_match #(.W(PA_W)) u_rgn (
    .addr(req_pa), .base(RGN_B), .size(RGN_SZ), .hit(pa_in_rgn)
  );

  eag_window_match #(.W(VA_W)) u_win (
    .addr(req_va), .base(win_base), .size(win_size), .hit(va_in_win)
  );

  eag_entry_check #(.OWN_W(OWN_W), .VPN_W(VPN_W)) u_ent (
    .kind      (kind_e'(req_kind)),
    .va_vpn    (req_va[VA_W-1:PAGE_SHIFT]),
    .cur_owner (cur_owner),
    .pg_valid  (pg_valid),
    .pg_type   (pgtype_e'(pg_type)),
    .pg_owner  (pg_owner),
    .pg_vpn    (pg_vpn),
    .pg_r      (pg_r),
    .pg_w      (pg_w),
    .pg_x      (pg_x),
    .bad_valid (e_valid),
    .bad_owner (e_owner),
    .bad_type  (e_type),
    .bad_addr  (e_addr),
    .bad_perm  (e_perm)
  );

  always_comb begin
    is_encl = src_e'(req_src) == SRC_ENCL;
    viol[0] = !is_encl && pa_in_rgn;
    viol[1] = is_encl && va_in_win && !pa_in_rgn;
    viol[2] = is_encl && pa_in_rgn && e_valid;
    viol[3] = is_encl && pa_in_rgn && e_owner;
    viol[4] = is_encl && pa_in_rgn && e_type;
    viol[5] = is_encl && pa_in_rgn && e_addr;
    viol[6] = is_encl && pa_in_rgn && e_perm;
  end

  eag_cause_pick #(.N(NUM_CHECKS)) u_pick (
    .viol(viol), .any_viol(any_viol), .cause(pick)
  );

  eag_cfg_check #(.W(VA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .base(win_base), .size(win_size), .err(cfg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_cause <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && !any_viol;
      rsp_cause <= req_valid ? pick : CAUSE_NONE;
    end
  end

  // R1/R2: outside agents touching the region are refused as region faults.
  a_r1_outside_agent_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_encl && pa_in_rgn) |=> (!rsp_allow && rsp_cause == CAUSE_REGION));

  // R4: in-window address translated off the region is a mapping fault.
  a_r4_window_off_region: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_encl && va_in_win && !pa_in_rgn) |=> (rsp_cause == CAUSE_MAP));

  // R6: a foreign page never lets an enclave through.
  a_r6_foreign_page: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_encl && pa_in_rgn && pg_owner != cur_owner) |=> !rsp_allow);

  // R10: outside window and region, an enclave access is allowed.
  a_r10_plain_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_encl && !va_in_win && !pa_in_rgn) |=> rsp_allow);

  // R13: a response follows every request by one cycle.
  a_r13_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R13: idle response carries no verdict.
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_allow && rsp_cause == 3'd0));

  // R11: an allowed response never carries a cause.
  a_r11_allow_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> (rsp_cause == 3'd0 && rsp_valid));
endmodule

// File: tb/enclave_access_guard_tb_top.sv
module enclave_access_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_va, req_pa, win_base, win_size;
  logic [1:0]  req_kind, req_src, pg_type;
  logic [7:0]  cur_owner, pg_owner;
  logic        pg_valid, pg_r, pg_w, pg_x, cfg_load;
  logic [19:0] pg_vpn;
  logic        rsp_valid, rsp_allow, cfg_err;
  logic [2:0]  rsp_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam longint RBASE = 64'h4000_0000;
  localparam longint RSIZE = 64'h0010_0000;

  always #2.5 clk = ~clk;

  enclave_access_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_pa(req_pa), .req_kind(req_kind), .req_src(req_src),
    .win_base(win_base), .win_size(win_size), .cur_owner(cur_owner),
    .pg_valid(pg_valid), .pg_type(pg_type), .pg_owner(pg_owner),
    .pg_vpn(pg_vpn), .pg_r(pg_r), .pg_w(pg_w), .pg_x(pg_x),
    .cfg_load(cfg_load), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_cause(rsp_cause), .cfg_err(cfg_err)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: magnitude compares, rule by rule in priority order.
  function automatic int ref_cause();
    longint va = longint'(req_va), pa = longint'(req_pa);
    bit in_rgn = (pa >= RBASE) && (pa < RBASE + RSIZE);
    bit in_win = (va >= longint'(win_base)) && (va < longint'(win_base) + longint'(win_size));
    bit ok;
    if (req_src != 0) return in_rgn ? 1 : 0;
    if (!in_rgn) return in_win ? 2 : 0;
    if (!pg_valid) return 3;
    if (pg_owner != cur_owner) return 4;
    if (pg_type != 0) return 5;
    if ((va / 4096) != longint'(pg_vpn)) return 6;
    case (req_kind)
      0: ok = pg_r;
      1: ok = pg_w;
      2: ok = pg_x;
      default: ok = 0;
    endcase
    return ok ? 0 : 7;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      1: return (req_src == 1) ? "R2" : "R1";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      default: return (req_src == 0) ? "R10" : "R2";
    endcase
  endfunction

  // A well-formed enclave access to page index pg inside the window.
  task automatic set_good(int pg, int kind);
    req_valid = 1; req_src = 0; req_kind = 2'(kind);
    req_va = win_base + 32'(pg * 4096) + 32'h10;
    req_pa = 32'(RBASE) + 32'(pg * 4096);
    pg_valid = 1; pg_type = 0; pg_owner = cur_owner;
    pg_vpn = req_va[31:12]; pg_r = 1; pg_w = 1; pg_x = 1;
  endtask

  // Apply at negedge, sample one negedge later (one register stage).
  task automatic run_one(string extra);
    int c = ref_cause();
    string t = (extra != "") ? extra : tag_of(c);
    @(negedge clk);
    check({t, " valid"}, rsp_valid, 1);
    check({t, " allow"}, rsp_allow, c == 0);
    check({t, " cause"}, rsp_cause, c);
    req_valid = 0;
  endtask

  task automatic load_cfg(logic [31:0] b, logic [31:0] s, bit exp_err);
    win_base = b; win_size = s; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    check("R12 cfg_err", cfg_err, exp_err);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; cfg_load = 0;
    req_va = 0; req_pa = 0; req_kind = 0; req_src = 0;
    win_base = 32'h0010_0000; win_size = 32'h0004_0000; cur_owner = 8'h5a;
    pg_valid = 0; pg_type = 0; pg_owner = 0; pg_vpn = 0; pg_r = 0; pg_w = 0; pg_x = 0;
    repeat (3) @(negedge clk);
    check("R13 reset rsp_valid", rsp_valid, 0);
    check("R13 reset allow", rsp_allow, 0);
    check("R13 reset cause", rsp_cause, 0);
    check("R13 reset cfg_err", cfg_err, 0);
    rst_n = 1;
    @(negedge clk);

    // R12 configuration checks
    load_cfg(32'h0010_0000, 32'h0004_0000, 0);
    load_cfg(32'h0010_0000, 32'h0000_3000, 1);
    load_cfg(32'h0010_2000, 32'h0000_4000, 1);
    load_cfg(32'h0010_0000, 32'h0000_0000, 1);
    @(negedge clk);
    check("R12 holds between loads", cfg_err, 1);
    load_cfg(32'h0010_0000, 32'h0004_0000, 0);

    // Directed: each cause alone
    set_good(3, 0); run_one("R9 good read");
    set_good(3, 1); pg_w = 0; run_one("R9 write no W");
    set_good(3, 2); pg_x = 0; pg_r = 1; run_one("R9 fetch no X");
    set_good(3, 3); run_one("R9 illegal kind");
    set_good(5, 0); pg_vpn = pg_vpn + 1; run_one("R8");
    set_good(5, 0); pg_type = 1; run_one("R7 control");
    set_good(5, 0); pg_type = 2; run_one("R7 thread");
    set_good(5, 0); pg_owner = 8'h11; run_one("R6");
    set_good(5, 0); pg_valid = 0; run_one("R5");
    set_good(5, 0); req_pa = 32'h2000_0000; run_one("R4");
    set_good(5, 0); req_va = 32'h0900_0000; req_pa = 32'h2000_0000; pg_valid = 0; run_one("R10");
    set_good(5, 0); req_src = 2; run_one("R1 dma");
    set_good(5, 0); req_src = 3; run_one("R1 src3");
    set_good(5, 0); req_src = 1; run_one("R2 host");
    set_good(5, 0); req_src = 1; req_pa = 32'h2000_0000; run_one("R2 host outside");
    // R3 window edges: last byte in, first byte past
    set_good(0, 0); req_va = 32'h0013_ffff; req_pa = 32'h2000_0000; run_one("R3 last in");
    set_good(0, 0); req_va = 32'h0014_0000; req_pa = 32'h2000_0000; run_one("R3 first out");
    // R11 priority: multiple failures
    set_good(2, 1); pg_valid = 0; pg_owner = 8'h1; pg_w = 0; run_one("R11 valid first");
    set_good(2, 1); pg_type = 2; pg_vpn = 0; pg_w = 0; run_one("R11 type first");
    set_good(2, 1); pg_owner = 8'h1; pg_type = 1; run_one("R11 owner first");

    // Biased random, several legal windows
    for (int w = 0; w < 3; w++) begin
      logic [31:0] sz = 32'h1000 << (2 + 3 * w);
      load_cfg(sz * 32'(w + 1), sz, 0);
      for (int n = 0; n < 150; n++) begin
        int pg = int'($urandom % 32'(sz / 32'h1000));
        set_good(pg, int'($urandom % 4));
        if ($urandom % 4 == 0) req_src = 2'($urandom);
        if ($urandom % 5 == 0) req_pa = $urandom;
        if ($urandom % 5 == 0) req_va = $urandom;
        if ($urandom % 6 == 0) pg_valid = 0;
        if ($urandom % 6 == 0) pg_owner = 8'($urandom);
        if ($urandom % 6 == 0) pg_type = 2'($urandom);
        if ($urandom % 6 == 0) pg_vpn = 20'($urandom);
        if ($urandom % 4 == 0) {pg_r, pg_w, pg_x} = 3'($urandom);
        run_one("");
      end
    end

    @(negedge clk);
    check("R13 idle after request", rsp_valid, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule